// File: doc/BRIEF.md
# Flash Page and Mass Erase Timing Sequencer

This block takes over the timing-critical part of erasing an on-chip flash array. Software (or another controller) requests an erase with a single start pulse, choosing between erasing one 128-byte page or the whole array, and between a short and a long erase interval. The sequencer then raises the erase-mode strobe, waits for confirmation that the block-protect setting was read, and captures the target page from the first write that lands in the array. After that it walks through the high-voltage handshake on its own. The phases are setup, high-voltage erase, high-voltage hold and read recovery, and each lasts at least its minimum time.

Every interval is given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter. Each phase holds for one cycle more than its nominal count, so no minimum is ever undercut. The long erase interval is intended for parts that will see more than a thousand erase cycles. The short one trades endurance for a quicker turnaround. While the sequence runs, the block watches the array's access strobes. Any read, or any write other than the one that selects the page, sets a sticky error flag.

Top module: `flash_erase_seq`

## Requirements
- R1: After a synchronous reset, erase_o, mass_o, hven_o, busy_o, done_o and err_o are 0 and rd_ready_o is 1.
- R2: A start_i seen while idle makes erase_o and busy_o 1 on the next cycle, with hven_o 0, rd_ready_o 0 and mass_o equal to the sampled mass_i (1 = whole array, 0 = one page).
- R3: While armed, the page is captured only by a write that comes after a cycle with prot_rd_i high. page_addr_o then equals wr_addr_i with its low 7 bits forced to 0. A write made before prot_rd_i captures nothing and the sequence stays armed with hven_o 0.
- R4: hven_o rises exactly 10·C+1 cycles after the capturing write's clock edge, where C = CLK_PER_US.
- R5: erase_o stays high together with hven_o for 1000·C+1 cycles when long_i was 0 at start, and for 4000·C+1 cycles when it was 1.
- R6: After erase_o falls, hven_o stays high for 5·C+1 cycles in page mode and for 100·C+1 cycles in mass mode.
- R7: After hven_o falls, busy_o stays high for C+1 cycles with rd_ready_o 0. Then done_o is 1 for exactly one cycle, in the same cycle in which busy_o falls and rd_ready_o rises.
- R8: A start_i seen while busy is ignored. mass_o and all phase lengths stay as set by the accepted start.
- R9: While busy, any rd_en_i, and any wr_en_i other than the capturing write, sets err_o. err_o then stays 1 until reset, and the sequence carries on unchanged.
- R10: A reset in the middle of a sequence returns all outputs to the R1 values, clearing err_o.
- R11: A start_i in the cycle where done_o is 1 is accepted, and an access in that cycle does not set err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Erase request pulse |
| mass_i | input | 1 | 1 = erase whole array, 0 = one page |
| long_i | input | 1 | 1 = long erase interval, 0 = short |
| prot_rd_i | input | 1 | Block-protect register has been read |
| wr_en_i | input | 1 | Write strobe into the array space |
| wr_addr_i | input | ADDR_W | Address of that write |
| rd_en_i | input | 1 | Read strobe into the array space |
| erase_o | output | 1 | Erase-mode strobe |
| mass_o | output | 1 | Whole-array select strobe |
| hven_o | output | 1 | High-voltage enable |
| page_addr_o | output | ADDR_W | Latched page base address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky access-violation flag |
| rd_ready_o | output | 1 | Array may be read normally |

## Verification
The end of one erase and the acceptance of the next can land in the same cycle. In the done cycle the bench drives start_i and rd_en_i together. It then expects a fresh armed sequence on the next cycle, with err_o still 0, because the block is no longer busy there. Starts that arrive inside a running sequence also overlap its phase counting. There the bench checks that the measured lengths of setup, erase, hold and recovery match the values computed from the first start's mode bits.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ARM     = 3'd1,
      ST_SETUP   = 3'd2,
      ST_ERASE   = 3'd3,
      ST_HOLD    = 3'd4,
      ST_RECOVER = 3'd5
   } fes_state_e;

   function automatic int us_to_cycles(input int us, input int cyc_per_us);
      return us * cyc_per_us;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fes_delay_timer.sv
module fes_delay_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/fes_page_latch.sv
module fes_page_latch #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] page_o
);

   logic [ADDR_W-1:0] keep_mask;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      if (b < OFF_W) begin : g_off
         assign keep_mask[b] = 1'b0;
      end else begin : g_page
         assign keep_mask[b] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         page_o <= '0;
      end else if (cap_i) begin
         page_o <= addr_i & keep_mask;
      end
   end

   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
      !cap_i |=> $stable(page_o)); // R3

endmodule

// File: rtl/fes_access_guard.sv
module fes_access_guard (
   input  logic clk,
   input  logic rst,
   input  logic busy_i,
   input  logic cap_i,
   input  logic rd_en_i,
   input  logic wr_en_i,
   output logic err_o
);

   logic violation;

   assign violation = busy_i && (rd_en_i || (wr_en_i && !cap_i));

   always_ff @(posedge clk) begin
      if (rst) begin
         err_o <= 1'b0;
      end else if (violation) begin
         err_o <= 1'b1;
      end
   end

   AST_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (busy_i && rd_en_i) |=> err_o); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o); // R9

endmodule

// File: rtl/fes_seq_ctrl.sv
module fes_seq_ctrl
   import fes_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int CYC_SETUP    = 10,
   parameter int CYC_ER_SHORT = 1000,
   parameter int CYC_ER_LONG  = 4000,
   parameter int CYC_HD_PAGE  = 5,
   parameter int CYC_HD_MASS  = 100,
   parameter int CYC_RECOVER  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             mass_i,
   input  logic             long_i,
   input  logic             prot_rd_i,
   input  logic             wr_en_i,
   input  logic             zero_i,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             cap_o,
   output logic             erase_o,
   output logic             mass_o,
   output logic             hven_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             rd_ready_o
);

   fes_state_e state_q;
   logic       prot_seen_q;
   logic       mass_q;
   logic       long_q;
   logic       last_tick;

   assign cap_o     = (state_q == ST_ARM) && wr_en_i && prot_seen_q;
   assign last_tick = (state_q == ST_RECOVER) && zero_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         prot_seen_q <= 1'b0;
         mass_q      <= 1'b0;
         long_q      <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q     <= ST_ARM;
                  mass_q      <= mass_i;
                  long_q      <= long_i;
                  prot_seen_q <= 1'b0;
               end
            end
            ST_ARM: begin
               if (prot_rd_i) prot_seen_q <= 1'b1;
               if (cap_o) state_q <= ST_SETUP;
            end
            ST_SETUP:   if (zero_i) state_q <= ST_ERASE;
            ST_ERASE:   if (zero_i) state_q <= ST_HOLD;
            ST_HOLD:    if (zero_i) state_q <= ST_RECOVER;
            ST_RECOVER: begin
               if (zero_i) begin
                  state_q <= ST_IDLE;
                  done_o  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load_o     = 1'b0;
      load_val_o = '0;
      unique case (state_q)
         ST_ARM: if (cap_o) begin
            load_o     = 1'b1;
            load_val_o = CNT_W'(CYC_SETUP);
         end
         ST_SETUP: if (zero_i) begin
            load_o     = 1'b1;
            load_val_o = long_q ? CNT_W'(CYC_ER_LONG) : CNT_W'(CYC_ER_SHORT);
         end
         ST_ERASE: if (zero_i) begin
            load_o     = 1'b1;
            load_val_o = mass_q ? CNT_W'(CYC_HD_MASS) : CNT_W'(CYC_HD_PAGE);
         end
         ST_HOLD: if (zero_i) begin
            load_o     = 1'b1;
            load_val_o = CNT_W'(CYC_RECOVER);
         end
         default: ;
      endcase
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign erase_o    = (state_q == ST_ARM) || (state_q == ST_SETUP) || (state_q == ST_ERASE);
   assign hven_o     = (state_q == ST_ERASE) || (state_q == ST_HOLD);
   assign mass_o     = busy_o && mass_q;
   assign rd_ready_o = !busy_o;

   AST_HV_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
      $rose(hven_o) |-> erase_o); // R4
   AST_ERASE_DROPS_UNDER_HV: assert property (@(posedge clk) disable iff (rst)
      ($fell(erase_o) && !$past(rst)) |-> hven_o); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && rd_ready_o)); // R7
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !last_tick) |=> $stable(mass_o)); // R8

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int PAGE_BYTES       = 128,
   parameter int CLK_PER_US       = 8,
   parameter int T_SETUP_US       = 10,
   parameter int T_ERASE_SHORT_US = 1000,
   parameter int T_ERASE_LONG_US  = 4000,
   parameter int T_HOLD_PAGE_US   = 5,
   parameter int T_HOLD_MASS_US   = 100,
   parameter int T_RECOVER_US     = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              mass_i,
   input  logic              long_i,
   input  logic              prot_rd_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              rd_en_i,
   output logic              erase_o,
   output logic              mass_o,
   output logic              hven_o,
   output logic [ADDR_W-1:0] page_addr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              rd_ready_o
);

   localparam int OFF_W        = $clog2(PAGE_BYTES);
   localparam int CYC_SETUP    = us_to_cycles(T_SETUP_US, CLK_PER_US);
   localparam int CYC_ER_SHORT = us_to_cycles(T_ERASE_SHORT_US, CLK_PER_US);
   localparam int CYC_ER_LONG  = us_to_cycles(T_ERASE_LONG_US, CLK_PER_US);
   localparam int CYC_HD_PAGE  = us_to_cycles(T_HOLD_PAGE_US, CLK_PER_US);
   localparam int CYC_HD_MASS  = us_to_cycles(T_HOLD_MASS_US, CLK_PER_US);
   localparam int CYC_RECOVER  = us_to_cycles(T_RECOVER_US, CLK_PER_US);
   localparam int CYC_MAX      = max2(max2(max2(CYC_SETUP, CYC_ER_SHORT), max2(CYC_ER_LONG, CYC_HD_PAGE)),
                                      max2(CYC_HD_MASS, CYC_RECOVER));
   localparam int CNT_W        = $clog2(CYC_MAX + 1);

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_chk_addr
      $error("ADDR_W must exceed the page offset width");
   end
   if (CLK_PER_US < 1) begin : g_chk_clk
      $error("CLK_PER_US must be at least 1");
   end
   if (T_ERASE_LONG_US < T_ERASE_SHORT_US) begin : g_chk_erase
      $error("long erase interval must not be shorter than the short one");
   end

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             cap;

   fes_seq_ctrl #(
      .CNT_W        (CNT_W),
      .CYC_SETUP    (CYC_SETUP),
      .CYC_ER_SHORT (CYC_ER_SHORT),
      .CYC_ER_LONG  (CYC_ER_LONG),
      .CYC_HD_PAGE  (CYC_HD_PAGE),
      .CYC_HD_MASS  (CYC_HD_MASS),
      .CYC_RECOVER  (CYC_RECOVER)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start_i),
      .mass_i     (mass_i),
      .long_i     (long_i),
      .prot_rd_i  (prot_rd_i),
      .wr_en_i    (wr_en_i),
      .zero_i     (tmr_zero),
      .load_o     (tmr_load),
      .load_val_o (tmr_val),
      .cap_o      (cap),
      .erase_o    (erase_o),
      .mass_o     (mass_o),
      .hven_o     (hven_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .rd_ready_o (rd_ready_o)
   );

   fes_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   fes_page_latch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .cap_i  (cap),
      .addr_i (wr_addr_i),
      .page_o (page_addr_o)
   );

   fes_access_guard u_guard (
      .clk     (clk),
      .rst     (rst),
      .busy_i  (busy_o),
      .cap_i   (cap),
      .rd_en_i (rd_en_i),
      .wr_en_i (wr_en_i),
      .err_o   (err_o)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!busy_o && !hven_o && !erase_o && !err_o)); // R10

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/100ps
module flash_erase_seq_tb;

   localparam int C  = 2;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0, mass_i = 1'b0, long_i = 1'b0;
   logic          prot_rd_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
   logic [AW-1:0] wr_addr_i = '0;
   logic          erase_o, mass_o, hven_o, busy_o, done_o, err_o, rd_ready_o;
   logic [AW-1:0] page_addr_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  exp_err = 1'b0;
   bit  finished = 1'b0;
   int  seed_dummy;

   always #2.5 clk = ~clk;

   flash_erase_seq #(.ADDR_W(AW), .CLK_PER_US(C)) u_dut (
      .clk(clk), .rst(rst), .start_i(start_i), .mass_i(mass_i), .long_i(long_i),
      .prot_rd_i(prot_rd_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .rd_en_i(rd_en_i),
      .erase_o(erase_o), .mass_o(mass_o), .hven_o(hven_o), .page_addr_o(page_addr_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rd_ready_o(rd_ready_o)
   );

   function automatic int exp_setup();
      return 10 * C + 1;
   endfunction
   function automatic int exp_erase(input bit lng);
      return (lng ? 4000 : 1000) * C + 1;
   endfunction
   function automatic int exp_hold(input bit mss);
      return (mss ? 100 : 5) * C + 1;
   endfunction
   function automatic int exp_rcv();
      return C + 1;
   endfunction
   function automatic logic [AW-1:0] page_of(input logic [AW-1:0] a);
      return a & ~16'h007F;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      exp_err = 1'b0;
   endtask

   task automatic seq_start(input bit mss, input bit lng);
      start_i = 1'b1; mass_i = mss; long_i = lng;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 busy", busy_o, 1);
      chk("R2 erase", erase_o, 1);
      chk("R2 hven", hven_o, 0);
      chk("R2 rd_ready", rd_ready_o, 0);
      chk("R2 mass", mass_o, mss);
   endtask

   task automatic seq_body(input bit mss, input bit lng, input logic [AW-1:0] addr,
                           input int pd, input int wd, input bit inj_start, input bit inj_rd);
      int n;
      repeat (pd) @(negedge clk);
      prot_rd_i = 1'b1;
      @(negedge clk);
      prot_rd_i = 1'b0;
      repeat (wd) @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = addr;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R3 page address", page_addr_o, page_of(addr));
      n = 0;
      while (!hven_o && n < 100000) begin
         n++;
         if (inj_start && n == 2) begin start_i = 1'b1; mass_i = !mss; long_i = !lng; end
         if (n == 3) begin start_i = 1'b0; mass_i = mss; long_i = lng; end
         @(negedge clk);
      end
      chk("R4 setup length", n, exp_setup());
      chk("R8 mass held after busy start", mass_o, mss);
      n = 0;
      while (erase_o && n < 100000) begin
         n++;
         if (inj_rd && n == 5) begin rd_en_i = 1'b1; exp_err = 1'b1; end
         if (n == 6) rd_en_i = 1'b0;
         @(negedge clk);
      end
      chk("R5 erase length", n, exp_erase(lng));
      chk("R6 hven after erase drop", hven_o, 1);
      n = 0;
      while (hven_o && n < 100000) begin n++; @(negedge clk); end
      chk("R6 hold length", n, exp_hold(mss));
      chk("R7 rd_ready in recovery", rd_ready_o, 0);
      n = 0;
      while (busy_o && n < 100000) begin n++; @(negedge clk); end
      chk("R7 recovery length", n, exp_rcv());
      chk("R7 done pulse", done_o, 1);
      chk("R7 rd_ready at end", rd_ready_o, 1);
      chk("R9 err flag", err_o, exp_err);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL R7 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 erase", erase_o, 0);
      chk("R1 mass", mass_o, 0);
      chk("R1 hven", hven_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 err", err_o, 0);
      chk("R1 rd_ready", rd_ready_o, 1);

      // directed: page short, then mass long with busy start
      seq_start(1'b0, 1'b0);
      seq_body(1'b0, 1'b0, 16'h12FF, 0, 0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R7 done one cycle", done_o, 0);
      seq_start(1'b1, 1'b1);
      seq_body(1'b1, 1'b1, 16'hFF80, 2, 3, 1'b1, 1'b0);
      @(negedge clk);

      // R3: write before protect read does not capture, flags error
      seq_start(1'b0, 1'b0);
      wr_en_i = 1'b1; wr_addr_i = 16'h4444;
      @(negedge clk);
      wr_en_i = 1'b0;
      exp_err = 1'b1;
      chk("R9 early write error", err_o, 1);
      repeat (40) @(negedge clk);
      chk("R3 no hven before capture", hven_o, 0);
      chk("R3 page unchanged", page_addr_o, page_of(16'hFF80));
      chk("R3 still armed", erase_o, 1);
      seq_body(1'b0, 1'b0, 16'h0281, 0, 1, 1'b0, 1'b1);
      // R11: start and read in the done cycle
      start_i = 1'b1; mass_i = 1'b0; long_i = 1'b0; rd_en_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; rd_en_i = 1'b0;
      chk("R11 start accepted on done cycle", busy_o, 1);
      chk("R11 erase raised", erase_o, 1);
      do_reset();
      chk("R11 R10 err cleared", err_o, 0);
      seq_start(1'b0, 1'b0);
      seq_body(1'b0, 1'b0, 16'h0100, 1, 0, 1'b0, 1'b0);
      start_i = 1'b1; rd_en_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; rd_en_i = 1'b0;
      chk("R11 busy again", busy_o, 1);
      chk("R11 access in done cycle no error", err_o, 0);
      seq_body(1'b0, 1'b0, 16'h0200, 0, 0, 1'b0, 1'b0);
      @(negedge clk);

      // R10: reset mid erase
      seq_start(1'b1, 1'b0);
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      chk("R9 read while armed", err_o, 1);
      prot_rd_i = 1'b1; @(negedge clk); prot_rd_i = 1'b0;
      wr_en_i = 1'b1; wr_addr_i = 16'h0900; @(negedge clk); wr_en_i = 1'b0;
      repeat (300) @(negedge clk);
      chk("R10 hven before reset", hven_o, 1);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      exp_err = 1'b0;
      chk("R10 busy", busy_o, 0);
      chk("R10 hven", hven_o, 0);
      chk("R10 erase", erase_o, 0);
      chk("R10 mass", mass_o, 0);
      chk("R10 err", err_o, 0);
      chk("R10 rd_ready", rd_ready_o, 1);
      @(negedge clk);

      // constrained random sequences
      for (int it = 0; it < 6; it++) begin
         bit            rm, rl, rs, rr;
         logic [AW-1:0] ra;
         int            rp, rw;
         rm = 1'($urandom % 2);
         rl = ($urandom % 4) == 0;
         rs = 1'($urandom % 2);
         rr = 1'($urandom % 2);
         ra = AW'($urandom);
         rp = int'($urandom % 5);
         rw = int'($urandom % 5);
         seq_start(rm, rl);
         seq_body(rm, rl, ra, rp, rw, rs, rr);
         @(negedge clk);
         chk("R7 done cleared", done_o, 0);
         if (exp_err) do_reset();
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule